// File: doc/BRIEF.md
# Oversampled serial receiver with break recognition

This block receives asynchronous serial characters from a single line that is sampled at sixteen times the bit rate. A qualifying pulse on the sample-tick input advances the receiver. A falling edge begins a frame. The start bit is confirmed at its middle, and each data bit and the stop position are then taken at their midpoints. A mode input selects characters of eight or nine data bits. In nine-bit mode the last data bit goes to a separate output.

Each finished frame is sorted into one of three kinds: an ordinary character, a character with a bad stop bit, or a break. A break is a frame in which every data bit and the stop position read low. It is reported with its own flag, together with the framing-error and receiver-full flags, and it forces the stored character and ninth bit to zero. After any frame whose stop position was low, the receiver waits for the line to go high again. One long low period therefore produces one break and not a run of frames.

Software clears the flags by pulsing the status-read strobe and then the data-read strobe. If a frame finishes while the previous character is still unread, only the overrun flag is set.

Top module: `serial_rx_brk`

## Requirements
- R1: A start is taken on a tick where the line is low and was high at the previous tick. Counting that tick as the first, it is confirmed only if the line is still low at the 8th tick. Otherwise the receiver returns to idle and reports nothing.
- R2: In 8-bit mode (mode9 = 0), eight bits are taken LSB first, one every 16 ticks after the confirmation. If the stop position reads high, they are stored in rx_data, rx_bit8 reads 0, rx_full is set, and frm_err and brk_flag stay 0.
- R3: In 9-bit mode (mode9 = 1, sampled at start confirmation), nine bits are taken. The first eight go to rx_data bits 0 to 7 and the ninth goes to rx_bit8.
- R4: A frame whose stop position reads low but has at least one data bit high stores its data, sets rx_full and frm_err, and leaves brk_flag at 0.
- R5: A frame whose data bits (eight or nine) and stop position all read low sets brk_flag, frm_err and rx_full, and drives rx_data to 0 and rx_bit8 to 0.
- R6: After a low stop position, no new start is accepted until the line has been seen high at a tick. A line held low long after a break yields exactly one frame.
- R7: rx_busy is high from the tick that confirms the start until the tick that samples the stop position, and low otherwise.
- R8: If a frame finishes while rx_full is still set, ovr_flag is set. rx_data, rx_bit8, frm_err and brk_flag keep their previous values.
- R9: A data_rd pulse that follows a stat_rd pulse clears rx_full, frm_err, brk_flag and ovr_flag on the next edge. A data_rd pulse with no stat_rd since the last clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| mode9 | input | 1 | 1 selects nine data bits, 0 selects eight |
| stat_rd | input | 1 | Status-read strobe, arms flag clearing |
| data_rd | input | 1 | Data-read strobe, clears flags when armed |
| rx_data | output | 8 | Received character bits 0 to 7 |
| rx_bit8 | output | 1 | Received ninth bit |
| rx_full | output | 1 | Unread character present |
| frm_err | output | 1 | Stop position read low |
| brk_flag | output | 1 | Break frame received |
| ovr_flag | output | 1 | Frame finished while previous was unread |
| rx_busy | output | 1 | Frame reception in progress |

## Verification
Ordinary eight-bit and nine-bit characters with a high stop bit show that data and the ninth bit land in the right places with no error. Frames with a low stop bit but one data bit high, in each mode (including one where only the ninth bit is high), show that a framing error is kept apart from a break. All-zero frames in both modes, held low well past the stop position, show break recognition, zeroing of the data outputs and the single-frame rule. A short low glitch, an unread character followed by a break, and a data read with no preceding status read cover start rejection, overrun and the clearing order.

// File: rtl/serial_rx_brk.sv
module serial_rx_brk #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       tick16,
  input  logic       mode9,
  input  logic       stat_rd,
  input  logic       data_rd,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       rx_full,
  output logic       frm_err,
  output logic       brk_flag,
  output logic       ovr_flag,
  output logic       rx_busy
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_HOLD} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [3:0]  idx;
  logic [8:0]  sh;
  logic        m9, prev, armed;

  wire clr  = data_rd & armed;
  wire last = (cnt == CW'(OVS - 1));
  wire done = tick16 && (st == S_STOP) && last;

  assign rx_busy = (st == S_DATA) || (st == S_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      m9   <= 1'b0;
      prev <= 1'b1;
    end else if (tick16) begin
      prev <= rxd;
      case (st)
        S_IDLE:
          if (prev && !rxd) begin
            st  <= S_START;
            cnt <= CW'(1);
          end
        S_START:
          if (cnt == CW'(MID - 1)) begin
            if (!rxd) begin
              st  <= S_DATA;
              cnt <= '0;
              idx <= '0;
              sh  <= '0;
              m9  <= mode9;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_DATA:
          if (last) begin
            sh[idx] <= rxd;
            cnt     <= '0;
            if (idx == (m9 ? 4'd8 : 4'd7)) st <= S_STOP;
            else idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_STOP:
          if (last) begin
            st  <= rxd ? S_IDLE : S_HOLD;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_HOLD:
          if (rxd) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_bit8  <= 1'b0;
      rx_full  <= 1'b0;
      frm_err  <= 1'b0;
      brk_flag <= 1'b0;
      ovr_flag <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (clr) armed <= 1'b0;
      if (stat_rd) armed <= 1'b1;
      if (clr) begin
        rx_full  <= 1'b0;
        frm_err  <= 1'b0;
        brk_flag <= 1'b0;
        ovr_flag <= 1'b0;
      end
      if (done) begin
        if (rx_full && !clr) begin
          ovr_flag <= 1'b1;
        end else begin
          rx_full  <= 1'b1;
          frm_err  <= !rxd;
          brk_flag <= !rxd && (sh == 9'd0);
          rx_data  <= sh[7:0];
          rx_bit8  <= sh[8];
        end
      end
    end
  end
endmodule

module serial_rx_brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       data_rd,
  input logic [7:0] rx_data,
  input logic       rx_bit8,
  input logic       rx_full,
  input logic       frm_err,
  input logic       brk_flag,
  input logic       ovr_flag,
  input logic       rx_busy
);
  p_brk_has_fe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag |-> frm_err);
  p_brk_has_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag |-> rx_full);
  p_brk_zero_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> (rx_data == 8'd0) && !rx_bit8);
  p_full_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_busy));
  p_full_fall_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(data_rd));
  p_ovr_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(rx_full));
endmodule

bind serial_rx_brk serial_rx_brk_chk u_chk (.*);

// File: tb/test_serial_rx_brk.sv
module test_serial_rx_brk;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, tick = 1'b0;
  logic mode9 = 1'b0, stat_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit8, rx_full, frm_err, brk_flag, ovr_flag, rx_busy;
  int checks = 0, errors = 0, divc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_rx_brk i_serial_rx_brk (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick), .mode9(mode9),
    .stat_rd(stat_rd), .data_rd(data_rd), .rx_data(rx_data), .rx_bit8(rx_bit8),
    .rx_full(rx_full), .frm_err(frm_err), .brk_flag(brk_flag),
    .ovr_flag(ovr_flag), .rx_busy(rx_busy));

  always @(negedge clk) begin
    divc <= (divc + 1) % 4;
    tick <= (divc == 3);
  end

  // behavioural reference: 0 idle, 1 start, 2 data, 3 stop, 4 wait high
  int mst = 0, tpos = 0;
  bit mbits[$];
  bit mprev = 1, mm9 = 0, marmed = 0, mclr = 0;
  logic [7:0] m_data = 0;
  bit m_b8 = 0, m_full = 0, m_fe = 0, m_brk = 0, m_ovr = 0;

  task automatic m_finish(input bit s);
    bit allz = 1;
    foreach (mbits[i]) if (mbits[i]) allz = 0;
    if (m_full) m_ovr = 1;
    else begin
      for (int i = 0; i < 8; i++) m_data[i] = mbits[i];
      m_b8  = mm9 ? mbits[8] : 1'b0;
      m_full = 1;
      m_fe  = !s;
      m_brk = !s && allz;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; tpos = 0; mprev = 1; mm9 = 0; marmed = 0;
      m_data = 0; m_b8 = 0; m_full = 0; m_fe = 0; m_brk = 0; m_ovr = 0;
    end else begin
      mclr = data_rd && marmed;
      if (mclr) marmed = 0;
      if (stat_rd) marmed = 1;
      if (mclr) begin m_full = 0; m_fe = 0; m_brk = 0; m_ovr = 0; end
      if (tick) begin
        case (mst)
          0: if (mprev && !rxd) begin mst = 1; tpos = 1; end
          1: begin
            tpos++;
            if (tpos == 8) begin
              if (!rxd) begin mst = 2; mbits.delete(); mm9 = mode9; end
              else mst = 0;
            end
          end
          2: begin
            tpos++;
            if ((tpos - 8) % 16 == 0) begin
              mbits.push_back(rxd);
              if (mbits.size() == (mm9 ? 9 : 8)) mst = 3;
            end
          end
          3: begin
            tpos++;
            if ((tpos - 8) % 16 == 0) begin
              m_finish(rxd);
              mst = rxd ? 0 : 4;
            end
          end
          default: if (rxd) mst = 0;
        endcase
        mprev = rxd;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk(rx_data === m_data, "R2", "rx_data", rx_data, m_data);
    chk(rx_bit8 === m_b8,   "R3", "rx_bit8", rx_bit8, m_b8);
    chk(rx_full === m_full, "R2", "rx_full", rx_full, m_full);
    chk(frm_err === m_fe,   "R4", "frm_err", frm_err, m_fe);
    chk(brk_flag === m_brk, "R5", "brk_flag", brk_flag, m_brk);
    chk(ovr_flag === m_ovr, "R8", "ovr_flag", ovr_flag, m_ovr);
    chk(rx_busy === (mst == 2 || mst == 3), "R7", "rx_busy", rx_busy, (mst == 2 || mst == 3));
  end

  task automatic wt(input int n);
    repeat (4 * n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int n, input bit stop, input int hold);
    rxd = 1'b0; wt(16);
    chk(rx_busy == 1'b1, "R7", "busy after start", rx_busy, 1);
    for (int i = 0; i < n; i++) begin rxd = d[i]; wt(16); end
    rxd = stop; wt(16);
    wt(hold);
    rxd = 1'b1; wt(4);
  endtask

  task automatic rd_clear();
    stat_rd = 1'b1; @(negedge clk);
    stat_rd = 1'b0; data_rd = 1'b1; @(negedge clk);
    data_rd = 1'b0; @(negedge clk);
    chk(rx_full == 0 && frm_err == 0 && brk_flag == 0 && ovr_flag == 0,
        "R9", "flags after clear", {rx_full, frm_err, brk_flag, ovr_flag}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen;
    repeat (6) @(negedge clk);
    chk({rx_data, rx_bit8, rx_full, frm_err, brk_flag, ovr_flag, rx_busy} == 0,
        "R2", "reset state", {rx_data, rx_bit8, rx_full, frm_err, brk_flag, ovr_flag, rx_busy}, 0);
    rst_n = 1'b1; wt(4);

    mode9 = 0; send(9'h0A5, 8, 1, 0);
    chk(rx_full && rx_data == 8'hA5 && !rx_bit8 && !frm_err && !brk_flag, "R2",
        "8-bit char", rx_data, 8'hA5);
    rd_clear();

    mode9 = 1; send(9'h13C, 9, 1, 0);
    chk(rx_data == 8'h3C && rx_bit8 == 1'b1, "R3", "9-bit char", {rx_bit8, rx_data}, 9'h13C);
    rd_clear();

    mode9 = 0; send(9'h001, 8, 0, 0);
    chk(frm_err && !brk_flag && rx_data == 8'h01, "R4", "stop low, data 01",
        {frm_err, brk_flag, rx_data}, {2'b10, 8'h01});
    rd_clear();

    mode9 = 1; send(9'h100, 9, 0, 0);
    chk(frm_err && !brk_flag && rx_data == 0 && rx_bit8, "R4", "stop low, ninth high",
        {frm_err, brk_flag, rx_bit8}, 3'b101);
    rd_clear();

    mode9 = 0; send(9'h000, 8, 0, 40);
    chk(brk_flag && frm_err && rx_full && rx_data == 0 && !rx_bit8, "R5", "8-bit break",
        {brk_flag, frm_err, rx_full, rx_bit8, rx_data}, {3'b111, 9'h000});
    chk(!ovr_flag && !rx_busy, "R6", "one frame for long low", {ovr_flag, rx_busy}, 0);
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
    chk(rx_full && brk_flag && frm_err, "R9", "data read alone ignored",
        {rx_full, brk_flag, frm_err}, 3'b111);
    rd_clear();

    mode9 = 1; send(9'h0FF, 9, 1, 0);
    rd_clear();
    send(9'h000, 9, 0, 20);
    chk(brk_flag && rx_data == 0 && !rx_bit8, "R5", "9-bit break",
        {brk_flag, rx_bit8, rx_data}, {2'b10, 8'h00});
    rd_clear();

    mode9 = 0; send(9'h05A, 8, 1, 0);
    send(9'h000, 8, 0, 10);
    chk(ovr_flag && rx_data == 8'h5A && !brk_flag && !frm_err, "R8", "overrun keeps data",
        {ovr_flag, brk_flag, frm_err, rx_data}, {3'b100, 8'h5A});
    rd_clear();

    seen = 0;
    rxd = 1'b0;
    repeat (12) begin @(negedge clk); if (rx_busy) seen = 1; end
    rxd = 1'b1;
    repeat (80) begin @(negedge clk); if (rx_busy) seen = 1; end
    chk(!seen && !rx_full, "R1", "short glitch rejected", {seen, rx_full}, 0);

    mode9 = 0; send(9'h081, 8, 1, 0);
    chk(rx_data == 8'h81 && rx_full, "R1", "start after glitch", rx_data, 8'h81);
    rd_clear();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule